// File: doc/BRIEF.md
# Horner-Order Digit-Serial Binary Field Multiplier

This block multiplies two elements of GF(2^N), N = M·D, modulo a sparse field polynomial t^N + P0, where P0 has degree below D and at most four terms. Each operand and the running product are held as M cells of D bits. One shared D×D carry-less digit multiplier handles one operand digit pair per clock, so the gate count depends on D and not on M. A complete product takes M·M cycles.

The multiplier digit of B is consumed from the most significant one down. For each B digit, the digits of A are visited from lowest to highest. The A and product registers rotate by one cell per cycle so that the active digits always sit at a fixed position. A small sequencer chooses one of three datapath steps each cycle. The first is a plain accumulate. The second is an accumulate that also multiplies the product by t^D and folds the overflow back through P0. The third is a final accumulate that reduces only the top half. Two separate constant multipliers by P0 serve the second and third steps.

A caller pulses `start` with both operands valid. It then waits for the one-cycle `done` pulse, at which point `result` holds the product. `result` stays unchanged until the next accepted start.

Top module: `gf2h_horner_mul`

## Requirements
- R1: With operand bit k taken as the coefficient of t^k, `result` at `done` equals the carry-less product of `op_a` and `op_b` reduced modulo t^N + P0. The default configuration is N = 32, D = 8 and P0 = t^7 + t^6 + t + 1 (0xC3).
- R2: `done` is high in the cycle after the M·M-th rising edge that follows the edge accepting `start`, and it stays low in every cycle between those two edges.
- R3: A `start` pulse or an operand change while a product is in progress is ignored. The running product still completes on schedule with the value of the operands that were captured.
- R4: `done` is a single-cycle pulse: it is never high in two consecutive cycles.
- R5: After reset, `done` is 0 and `result` is 0.
- R6: While no product is running and `start` is low, `result` holds its value whatever `op_a` and `op_b` do.
- R7: A `start` raised in the cycle where `done` is high is accepted, so products can run back to back with no gap.
- R8: With the one-level split (Karatsuba) digit multiplier selected (KARA = 1, even D), results are identical to R1. This is checked on a configuration with M = 3, D = 4 and P0 = t^3 + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a product when no product is running |
| op_a | input | N | Multiplicand, bit k = coefficient of t^k |
| op_b | input | N | Multiplier, bit k = coefficient of t^k |
| done | output | 1 | One-cycle pulse marking a valid `result` |
| result | output | N | Product modulo t^N + P0 |

## Verification
The assertions take for granted that `start` is a clean synchronous level and that the operands are stable in the cycle `start` is accepted. Nothing is assumed about the inputs in any other cycle. The stimulus deliberately moves the operands and pulses `start` during computation and while idle, so the block's disregard of those inputs is exercised rather than assumed. The small split-multiplier configuration is swept over every 12-bit multiplicand against edge and pseudo-random multipliers, and the default configuration takes edge operands, a worked example and random pairs.

// File: rtl/gf2h_pkg.sv
package gf2h_pkg;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_ACC   = 2'd1,
      OP_SHIFT = 2'd2,
      OP_FINAL = 2'd3
   } step_e;

   function automatic int pop32(input logic [31:0] v);
      int n;
      n = 0;
      for (int k = 0; k < 32; k++) n += int'(v[k]);
      return n;
   endfunction

endpackage

// File: rtl/gf2h_digit_mul.sv
module gf2h_digit_mul #(
   parameter int W    = 8,
   parameter bit KARA = 1'b0
) (
   input  logic [W-1:0]   x,
   input  logic [W-1:0]   y,
   output logic [2*W-1:0] p
);
   localparam int H = W / 2;

   generate
      if (KARA) begin : g_split
         if ((W % 2) != 0 || W < 2) begin : g_bad
            $error("gf2h_digit_mul: split variant needs an even width");
         end
         logic [2*H-1:0] m_lo, m_hi, m_mid, mid;
         gf2h_digit_mul #(.W(H), .KARA(1'b0)) u_lo (
            .x(x[H-1:0]), .y(y[H-1:0]), .p(m_lo));
         gf2h_digit_mul #(.W(H), .KARA(1'b0)) u_hi (
            .x(x[W-1:H]), .y(y[W-1:H]), .p(m_hi));
         gf2h_digit_mul #(.W(H), .KARA(1'b0)) u_mid (
            .x(x[H-1:0] ^ x[W-1:H]), .y(y[H-1:0] ^ y[W-1:H]), .p(m_mid));
         assign mid = m_lo ^ m_hi ^ m_mid;
         assign p = {m_hi, m_lo} ^ ({{W{1'b0}}, mid} << H);
      end else begin : g_school
         always_comb begin
            p = '0;
            for (int i = 0; i < W; i++)
               for (int j = 0; j < W; j++)
                  p[i+j] = p[i+j] ^ (x[i] & y[j]);
         end
      end
   endgenerate

endmodule

// File: rtl/gf2h_const_mul.sv
module gf2h_const_mul #(
   parameter int             W  = 16,
   parameter int             D  = 8,
   parameter logic [D-1:0]   P0 = 8'hC3
) (
   input  logic [W-1:0]   x,
   output logic [W+D-1:0] y
);
   always_comb begin
      y = '0;
      for (int k = 0; k < D; k++)
         if (P0[k]) y = y ^ ({{D{1'b0}}, x} << k);
   end
endmodule

// File: rtl/gf2h_seq.sv
module gf2h_seq
   import gf2h_pkg::*;
#(
   parameter int M = 4
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  start,
   output step_e step,
   output logic  load,
   output logic  done
);
   localparam int JW = $clog2(M);
   localparam int LW = $clog2(M * M + 1) + 1;

   logic          busy_q;
   logic [JW-1:0] j_q, i_q;
   logic [LW-1:0] lat_q;

   always_comb begin
      load = start && !busy_q;
      if (!busy_q)                 step = OP_IDLE;
      else if (j_q != JW'(M - 1))  step = OP_ACC;
      else if (i_q != '0)          step = OP_SHIFT;
      else                         step = OP_FINAL;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         j_q    <= '0;
         i_q    <= '0;
         done   <= 1'b0;
         lat_q  <= '0;
      end else begin
         done <= (step == OP_FINAL);
         if (load) begin
            busy_q <= 1'b1;
            j_q    <= '0;
            i_q    <= JW'(M - 1);
            lat_q  <= '0;
         end else if (busy_q) begin
            lat_q <= lat_q + 1'b1;
            if (j_q == JW'(M - 1)) begin
               j_q <= '0;
               if (i_q == '0) busy_q <= 1'b0;
               else           i_q    <= i_q - 1'b1;
            end else begin
               j_q <= j_q + 1'b1;
            end
         end
      end
   end

   assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step == OP_FINAL) |-> (lat_q == LW'(M * M - 1)));
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && j_q != JW'(M - 1)) |=> (busy_q && j_q == $past(j_q) + 1'b1));

endmodule

// File: rtl/gf2h_horner_mul.sv
module gf2h_horner_mul
   import gf2h_pkg::*;
#(
   parameter int           M    = 4,
   parameter int           D    = 8,
   parameter logic [D-1:0] P0   = 8'hC3,
   parameter bit           KARA = 1'b0,
   localparam int          N    = M * D
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [N-1:0] op_a,
   input  logic [N-1:0] op_b,
   output logic         done,
   output logic [N-1:0] result
);
   localparam int P0_TERMS = pop32(32'(P0));

   generate
      if (M < 3) begin : g_bad_m
         $error("gf2h_horner_mul: M must be at least 3");
      end
      if (D < 2 || D > 32) begin : g_bad_d
         $error("gf2h_horner_mul: D must lie in 2..32");
      end
      if (P0_TERMS < 1 || P0_TERMS > 4) begin : g_bad_p0
         $error("gf2h_horner_mul: P0 needs one to four terms");
      end
   endgenerate

   step_e        step;
   logic         load;
   logic [D-1:0] a_q [M];
   logic [D-1:0] b_q [M];
   logic [D-1:0] c_q [M];

   logic [2*D-1:0] prod, temp, y3;
   logic [3*D-1:0] y2;
   logic [D-1:0]   ul, uh;

   gf2h_seq #(.M(M)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .step(step), .load(load), .done(done));

   gf2h_digit_mul #(.W(D), .KARA(KARA)) u_dmul (
      .x(a_q[0]), .y(b_q[M-1]), .p(prod));

   assign ul   = prod[D-1:0];
   assign uh   = prod[2*D-1:D];
   assign temp = prod ^ {{D{1'b0}}, c_q[0]};

   gf2h_const_mul #(.W(2*D), .D(D), .P0(P0)) u_fold_shift (.x(temp), .y(y2));
   gf2h_const_mul #(.W(D),   .D(D), .P0(P0)) u_fold_final (.x(uh),   .y(y3));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < M; k++) begin
            a_q[k] <= '0;
            b_q[k] <= '0;
            c_q[k] <= '0;
         end
      end else if (load) begin
         for (int k = 0; k < M; k++) begin
            a_q[k] <= op_a[k*D +: D];
            b_q[k] <= op_b[k*D +: D];
            c_q[k] <= '0;
         end
      end else begin
         case (step)
            OP_ACC: begin
               for (int k = 0; k < M; k++) begin
                  a_q[k] <= a_q[(k+1)%M];
                  c_q[k] <= c_q[(k+1)%M];
               end
               c_q[M-1] <= c_q[0] ^ ul;
               c_q[0]   <= c_q[1] ^ uh;
            end
            OP_SHIFT: begin
               for (int k = 0; k < M; k++) a_q[k] <= a_q[(k+1)%M];
               for (int k = 1; k < M; k++) b_q[k] <= b_q[k-1];
               b_q[0] <= '0;
               c_q[0] <= y2[D-1:0];
               c_q[1] <= c_q[1] ^ y2[2*D-1:D];
               c_q[2] <= c_q[2] ^ y2[3*D-1:2*D];
            end
            OP_FINAL: begin
               for (int k = 0; k < M; k++) begin
                  a_q[k] <= a_q[(k+1)%M];
                  c_q[k] <= c_q[(k+1)%M];
               end
               c_q[M-1] <= c_q[0] ^ ul;
               c_q[0]   <= c_q[1] ^ y3[D-1:0];
               c_q[1]   <= c_q[2] ^ y3[2*D-1:D];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      for (int k = 0; k < M; k++) result[k*D +: D] = c_q[k];
   end

   assert_final_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step == OP_FINAL) |=> done);
   assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step == OP_IDLE && !start) |=> $stable(result));
   assert_load_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (step == OP_ACC && result == '0));

endmodule

// File: tb/gf2h_horner_mul_test.sv
module gf2h_horner_mul_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st0 = 1'b0, st1 = 1'b0;
   logic [31:0] a0 = '0, b0 = '0;
   logic [11:0] a1 = '0, b1 = '0;
   logic        done0, done1;
   logic [31:0] res0;
   logic [11:0] res1;
   int          n_chk = 0, n_fail = 0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   gf2h_horner_mul uut (
      .clk(clk), .rst_n(rst_n), .start(st0), .op_a(a0), .op_b(b0),
      .done(done0), .result(res0));

   gf2h_horner_mul #(.M(3), .D(4), .P0(4'b1001), .KARA(1'b1)) uut_small (
      .clk(clk), .rst_n(rst_n), .start(st1), .op_a(a1), .op_b(b1),
      .done(done1), .result(res1));

   function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b,
                                            input int n, input logic [31:0] p0);
      logic [63:0] pr;
      pr = '0;
      for (int i = 0; i < n; i++) if (b[i]) pr = pr ^ (64'(a) << i);
      for (int k = 2 * n - 2; k >= n; k--)
         if (pr[k]) begin
            pr[k] = 1'b0;
            pr = pr ^ (64'(p0) << (k - n));
         end
      return pr[31:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic dn(input int sel);
      return (sel != 0) ? done1 : done0;
   endfunction

   function automatic logic [31:0] rs(input int sel);
      return (sel != 0) ? 32'(res1) : res0;
   endfunction

   task automatic drive(input int sel, input logic s, input logic [31:0] a,
                        input logic [31:0] b);
      if (sel != 0) begin st1 = s; a1 = a[11:0]; b1 = b[11:0]; end
      else          begin st0 = s; a0 = a;       b0 = b;       end
   endtask

   // called at a negedge; leaves the bench at the negedge where done is expected
   task automatic run_op(input int sel, input logic [31:0] a, input logic [31:0] b,
                         input bit glitch, input string tag);
      int          mm = (sel != 0) ? 9 : 16;
      int          n  = (sel != 0) ? 12 : 32;
      logic [31:0] p0 = (sel != 0) ? 32'h9 : 32'hC3;
      logic [31:0] exp;
      bit          early = 1'b0;
      exp = ref_mul(a, b, n, p0);
      drive(sel, 1'b1, a, b);
      @(negedge clk);
      drive(sel, 1'b0, a, b);
      for (int k = 1; k <= mm; k++) begin
         @(negedge clk);
         if (k < mm && dn(sel)) early = 1'b1;
         if (glitch && k == 2) drive(sel, 1'b1, ~a, b ^ 32'h5A5A5A5A);
         if (glitch && k == 3) drive(sel, 1'b0, a ^ 32'h0F0F0F0F, ~b);
      end
      chk(dn(sel) && !early, "R2 done timing", {31'b0, dn(sel)}, 32'h1);
      chk(rs(sel) == exp, tag, rs(sel), exp);
   endtask

   // R4 and R6: idle cycles with moving operands
   task automatic idle_check(input int sel);
      logic [31:0] held = rs(sel);
      @(negedge clk);
      chk(!dn(sel), "R4 done single pulse", {31'b0, dn(sel)}, 32'h0);
      for (int k = 0; k < 3; k++) begin
         drive(sel, 1'b0, $urandom, $urandom);
         @(negedge clk);
      end
      chk(rs(sel) == held, "R6 result held while idle", rs(sel), held);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(done0 == 1'b0 && done1 == 1'b0, "R5 done after reset",
          {30'b0, done1, done0}, 32'h0);
      chk(res0 == '0, "R5 result after reset", res0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(res0 == '0 && res1 == '0, "R5 result after release", res0 | 32'(res1), 32'h0);

      // R1 worked example and edge operands
      run_op(0, 32'h03000003, 32'h80000002, 1'b0, "R1 worked example");
      idle_check(0);
      begin
         logic [31:0] edges [4] = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h80000000};
         foreach (edges[x]) foreach (edges[y]) begin
            run_op(0, edges[x], edges[y], 1'b0, "R1 edge operands");
            idle_check(0);
         end
      end
      // R1 random, R3 mid-run disturbance, R7 back to back
      for (int r = 0; r < 600; r++) begin
         logic [31:0] a = $urandom, b = $urandom;
         if (r % 7 == 3)      run_op(0, a, b, 1'b1, "R3 start ignored while busy");
         else if (r % 5 == 1) run_op(0, a, b, 1'b0, "R7 back-to-back start");
         else                 run_op(0, a, b, 1'b0, "R1 random operands");
         if (r % 5 != 0) idle_check(0);
      end
      // R8 split multiplier: every 12-bit multiplicand
      for (int a = 0; a < 4096; a++) begin
         logic [31:0] b;
         case (a % 4)
            0: b = 32'h0;
            1: b = 32'h1;
            2: b = 32'hFFF;
            default: b = 32'($urandom) & 32'hFFF;
         endcase
         run_op(1, 32'(a), b, (a % 97) == 5, "R8 split digit multiplier");
      end
      idle_check(1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog R2 actual=%h expected=%h", 32'h0, 32'h1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule